// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two W-bit buses, side A and side B, through a path that can either pass data straight across or replay a value saved earlier. Each side owns a holding register that snapshots its own bus on the rising edge of that side's capture clock. Snapshots are taken whether or not any bus is being driven, so both sides can be captured while the block is isolated.

An active-low enable and a direction input choose which side, if any, the block drives. For each direction a select input chooses the source for the driven side. It is either the live value on the opposite bus or the snapshot held for the opposite bus. Each bidirectional pin group is split into an input vector, an output vector and one active-high output enable. A pad ring or testbench rebuilds the tri-state bus from these signals.

Top module: `regbus_xcvr`

## Requirements
- R1: On each rising edge of `a_clk`, the side-A register stores the value on `a_in`.
- R2: On each rising edge of `b_clk`, the side-B register stores the value on `b_in`.
- R3: Captures happen for every combination of `en_n` and `to_b`, including isolation (`en_n` = 1), with both registers loaded in the same cycle.
- R4: While `en_n` is 1, both `a_oe` and `b_oe` are 0.
- R5: While `en_n` is 0 and `to_b` is 0, `a_oe` is 1 and `b_oe` is 0.
- R6: While `en_n` is 0 and `to_b` is 1, `b_oe` is 1 and `a_oe` is 0.
- R7: While `a_oe` is 1, `a_out` equals `b_in` when `a_from_store` is 0, in the same cycle with no clock. It equals the side-B register when `a_from_store` is 1.
- R8: While `b_oe` is 1, `b_out` equals `a_in` when `b_from_store` is 0, in the same cycle with no clock. It equals the side-A register when `b_from_store` is 1.
- R9: `a_oe` and `b_oe` are never 1 together.
- R10: Driving `rst_n` low clears both registers to zero at once, without a clock edge.
- R11: An output whose enable is 0 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| a_clk | input | 1 | Rising edge stores `a_in` into the side-A register |
| b_clk | input | 1 | Rising edge stores `b_in` into the side-B register |
| en_n | input | 1 | Active-low drive enable; 1 isolates both sides |
| to_b | input | 1 | 0 drives side A, 1 drives side B |
| a_from_store | input | 1 | Source for side A: 0 live `b_in`, 1 side-B register |
| b_from_store | input | 1 | Source for side B: 0 live `a_in`, 1 side-A register |
| a_in | input | W | Value present on bus A |
| a_out | output | W | Value driven onto bus A, zero when not enabled |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Value present on bus B |
| b_out | output | W | Value driven onto bus B, zero when not enabled |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The bench stores values on both sides while isolated, then replays them through each direction. A design that gated capture with the enable would replay the reset zeros instead. It captures on side A while side B is being driven from that same register, which exposes a swapped select or swapped register pairing. It also changes the live input with no clock edge and expects the driven side to follow at once, so a pass-through wrongly put behind a register lags by one edge. A reset pulse between captures must clear both replays to zero, which catches a synchronous or partial clear.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;

  // Which side the block drives, from the enable and direction controls.
  function automatic drive_e pick_side(input logic en_n, input logic to_b);
    if (en_n) return DRV_NONE;
    return to_b ? DRV_B : DRV_A;
  endfunction

endpackage

// File: rtl/regbus_store.sv
module regbus_store #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         cap_clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge cap_clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/regbus_steer.sv
module regbus_steer
  import regbus_pkg::*;
(
  input  logic en_n,
  input  logic to_b,
  output logic drive_a,
  output logic drive_b
);
  drive_e side;

  always_comb begin
    side    = pick_side(en_n, to_b);
    drive_a = (side == DRV_A);
    drive_b = (side == DRV_B);
  end
endmodule

// File: rtl/regbus_route.sv
module regbus_route #(
  parameter int W = 8
) (
  input  logic         drive,
  input  logic         use_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out,
  output logic         oe
);
  function automatic logic [W-1:0] source(input logic en, input logic sel,
                                          input logic [W-1:0] l,
                                          input logic [W-1:0] s);
    if (!en) return '0;
    return sel ? s : l;
  endfunction

  assign out = source(drive, use_stored, live, stored);
  assign oe  = drive;
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         a_clk,
  input  logic         b_clk,
  input  logic         en_n,
  input  logic         to_b,
  input  logic         a_from_store,
  input  logic         b_from_store,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  localparam int SIDES = 2;

  logic [SIDES-1:0]        cap_clk;
  logic [SIDES-1:0][W-1:0] cap_d;
  logic [SIDES-1:0][W-1:0] cap_q;
  logic [W-1:0]            store_a_q;
  logic [W-1:0]            store_b_q;
  logic                    drive_a;
  logic                    drive_b;

  assign cap_clk = {b_clk, a_clk};
  assign cap_d   = {b_in, a_in};

  for (genvar s = 0; s < SIDES; s++) begin : g_store
    regbus_store #(.W(W)) u_store (
      .rst_n   (rst_n),
      .cap_clk (cap_clk[s]),
      .d       (cap_d[s]),
      .q       (cap_q[s])
    );
  end

  assign store_a_q = cap_q[0];
  assign store_b_q = cap_q[1];

  regbus_steer u_steer (
    .en_n    (en_n),
    .to_b    (to_b),
    .drive_a (drive_a),
    .drive_b (drive_b)
  );

  regbus_route #(.W(W)) u_route_a (
    .drive      (drive_a),
    .use_stored (a_from_store),
    .live       (b_in),
    .stored     (store_b_q),
    .out        (a_out),
    .oe         (a_oe)
  );

  regbus_route #(.W(W)) u_route_b (
    .drive      (drive_b),
    .use_stored (b_from_store),
    .live       (a_in),
    .stored     (store_a_q),
    .out        (b_out),
    .oe         (b_oe)
  );
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int W = 8
) (
  input logic         rst_n,
  input logic         a_clk,
  input logic         b_clk,
  input logic         en_n,
  input logic         to_b,
  input logic         a_from_store,
  input logic         b_from_store,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] store_a_q,
  input logic [W-1:0] store_b_q
);
  logic seen_a, seen_b;

  always_ff @(posedge a_clk or negedge rst_n) begin
    if (!rst_n) seen_a <= 1'b0;
    else        seen_a <= 1'b1;
  end

  always_ff @(posedge b_clk or negedge rst_n) begin
    if (!rst_n) seen_b <= 1'b0;
    else        seen_b <= 1'b1;
  end

  p_cap_a_r1: assert property (@(posedge a_clk) disable iff (!rst_n)
    seen_a |-> store_a_q == $past(a_in));
  p_cap_b_r2: assert property (@(posedge b_clk) disable iff (!rst_n)
    seen_b |-> store_b_q == $past(b_in));
  p_iso_r4: assert property (@(posedge a_clk) disable iff (!rst_n)
    en_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));
  p_drive_a_r5: assert property (@(posedge a_clk) disable iff (!rst_n)
    (!en_n && !to_b) |-> (a_oe && !b_oe));
  p_drive_b_r6: assert property (@(posedge b_clk) disable iff (!rst_n)
    (!en_n && to_b) |-> (b_oe && !a_oe));
  p_a_src_r7: assert property (@(posedge b_clk) disable iff (!rst_n)
    a_oe |-> a_out == (a_from_store ? store_b_q : b_in));
  p_b_src_r8: assert property (@(posedge a_clk) disable iff (!rst_n)
    b_oe |-> b_out == (b_from_store ? store_a_q : a_in));
  p_one_side_r9: assert property (@(posedge a_clk) disable iff (!rst_n)
    $countones({a_oe, b_oe}) <= 1);
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/regbus_xcvr_test.sv
module regbus_xcvr_test;
  localparam int W = 8;
  localparam int NV = 10;

  typedef struct packed {
    logic         en_n, to_b, b_st, a_st, pa, pb;
    logic [W-1:0] a, b;
    logic         xa_oe, xb_oe;
    logic [W-1:0] xa, xb;
  } vec_t;

  // Registers start at zero. Stored values follow the comments.
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,8'h11,8'h22,1'b0,1'b0,8'h00,8'h00}, // R3 iso capture A=11 B=22
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h33,8'h44,1'b1,1'b0,8'h44,8'h00}, // live B->A
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h33,8'h44,1'b1,1'b0,8'h22,8'h00}, // stored B->A
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'h55,8'h44,1'b0,1'b1,8'h00,8'h55}, // live A->B
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h55,8'h44,1'b0,1'b1,8'h00,8'h11}, // stored A->B
    '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,8'h66,8'h44,1'b0,1'b1,8'h00,8'h66}, // R1 A=66 while driving B
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,8'h66,8'h77,1'b1,1'b0,8'h77,8'h00}, // R2 B=77 while driving A
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h66,8'h77,1'b0,1'b0,8'h00,8'h00}, // isolation
    '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,8'hAA,8'h99,1'b1,1'b0,8'h77,8'h00}, // A=AA, B kept 77
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'hAA,8'h99,1'b0,1'b1,8'h00,8'hAA}  // replay A=AA
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, a_clk, b_clk, en_n, to_b, a_from_store, b_from_store;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  regbus_xcvr #(.W(W)) uut (
    .rst_n(rst_n), .a_clk(a_clk), .b_clk(b_clk), .en_n(en_n), .to_b(to_b),
    .a_from_store(a_from_store), .b_from_store(b_from_store),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    en_n = v.en_n; to_b = v.to_b; b_from_store = v.b_st; a_from_store = v.a_st;
    a_in = v.a; b_in = v.b;
    @(posedge clk);
    a_clk = v.pa; b_clk = v.pb;
    @(negedge clk);
    a_clk = 1'b0; b_clk = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; a_clk = 1'b0; b_clk = 1'b0; en_n = 1'b1; to_b = 1'b0;
    a_from_store = 1'b0; b_from_store = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    // R4 R11: reset state with isolation
    chk("R4 oe pair", {7'd0, a_oe, b_oe}, '0);
    chk("R11 a_out idle", {1'b0, a_out}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      chk(VECS[i].en_n ? "R4 enables" : (VECS[i].to_b ? "R6 enables" : "R5 enables"),
          {7'd0, a_oe, b_oe}, {7'd0, VECS[i].xa_oe, VECS[i].xb_oe});
      chk(VECS[i].xa_oe ? "R7 a_out" : "R11 a_out", {1'b0, a_out}, {1'b0, VECS[i].xa});
      chk(VECS[i].xb_oe ? "R8 b_out" : "R11 b_out", {1'b0, b_out}, {1'b0, VECS[i].xb});
      chk("R9 single side", {8'd0, a_oe & b_oe}, '0);
    end

    // R7: live pass-through follows b_in with no clock edge
    @(negedge clk);
    en_n = 1'b0; to_b = 1'b0; a_from_store = 1'b0; b_in = 8'h5A;
    #1 chk("R7 live no clock", {1'b0, a_out}, {1'b0, 8'h5A});
    b_in = 8'hC3;
    #1 chk("R7 live follows", {1'b0, a_out}, {1'b0, 8'hC3});
    // R8: live pass-through follows a_in with no clock edge
    to_b = 1'b1; b_from_store = 1'b0; a_in = 8'h3C;
    #1 chk("R8 live no clock", {1'b0, b_out}, {1'b0, 8'h3C});

    // R3: both captured at once in isolation, then replayed each way
    apply('{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,8'hE1,8'hD2,1'b0,1'b0,8'h00,8'h00});
    apply('{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,1'b0,8'h00,8'h00});
    chk("R3 B stored in isolation", {1'b0, a_out}, {1'b0, 8'hD2});
    apply('{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,1'b1,8'h00,8'h00});
    chk("R3 A stored in isolation", {1'b0, b_out}, {1'b0, 8'hE1});

    // R10: asynchronous clear without any clock edge
    #1 rst_n = 1'b0;
    #1 chk("R10 A cleared", {1'b0, b_out}, '0);
    to_b = 1'b0; a_from_store = 1'b1;
    #1 chk("R10 B cleared", {1'b0, a_out}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule